// File: doc/BRIEF.md
# Serial Flash Streaming Read Master

This block is an SPI master that pulls a sequential stream of data out of a serial flash and collects it as 32-bit words in a receive FIFO. Software drives it through a small word-wide register port. It first sends a read command word, which holds the opcode and the byte address, from the transmit FIFO. It then programs a word count and turns on reception. The master keeps clocking until exactly that many words have been received. When the transmit FIFO is empty it sends all-ones filler words, so the flash keeps streaming. Chip select is a plain software-controlled level, so one read can span any number of words.

Each received word is put together MSB first. Before it is written into the receive FIFO, it can be reordered by swapping the bytes inside each halfword, by swapping the two halfwords, or by both. A soft-reset bit empties both FIFOs, clears the packet progress and aborts any word in flight. Register map, by address: 0 control, 1 packet count, 2 swap, 3 chip select, 4 status (read only), 5 transmit data (write only), 6 receive data (read only, pops the FIFO). SCLK is the system clock divided by a fixed parameter. Data is shifted MSB first, the input is sampled on the leading SCLK edge and the output changes on the trailing edge. The control register holds the idle clock polarity in bit 2, and the flows below use polarity 0.

Top module: `spi_flash_stream_rd`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sclk is 0 and the status register (address 4) reads 32'h0000_0001.
- R2: Bit 0 of the chip-select register (address 3) drives spi_cs_n directly: writing 0 drives it low, writing 1 drives it high. The level only changes on a register write, so it stays low across any number of words.
- R3: A word taken from the transmit FIFO is shifted out MSB first, and each bit is valid at the leading SCLK edge. A read command word is 8'h03 in bits 31:24 followed by a 24-bit byte address in bits 23:0, and it takes exactly 32 SCLK cycles.
- R4: Status bit 0 (TX done) is 1 exactly when the transmit FIFO is empty and no word is being shifted. It rises once the last queued word has been shifted out.
- R5: The packet register (address 1) holds a word count in bits 15:0 and an enable in bit 16. With the enable and reception on, the master receives exactly that many words and then stops SCLK.
- R6: When the packet counter still needs words and the transmit FIFO is empty, the master sends all-ones filler words.
- R7: Received words enter the receive FIFO with the first bit received in bit 31. Each read of address 6 returns the oldest word and removes it.
- R8: Swap register (address 2): bit 0 enables swapping, bit 1 swaps the bytes inside each halfword, bit 2 swaps the two halfwords, and setting both reverses all four bytes. With bit 0 clear, words are stored unchanged whatever bits 1 and 2 hold.
- R9: The status register reports the receive FIFO level in bits 21:15 and the transmit FIFO level in bits 12:6.
- R10: The transmit FIFO holds 64 words. A write to address 5 while it is full is dropped.
- R11: Reading address 6 while the receive FIFO is empty returns 0 and sets status bit 1. The bit is sticky and stays set across further reads.
- R12: Control bit 3 (soft reset) empties both FIFOs, clears the packet progress and clears status bit 1. After it is released, a new count of words is received in full.
- R13: Control bit 0 enables the transmit path and bit 1 enables the receive path. With bit 0 clear, queued transmit words are held and not sent. With bit 1 clear, no words are clocked for the packet counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive FIFO at address 6) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for the addressed register |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The hardest state to reach is a long receive that crosses several reconfigurations while chip select stays low. Packet progress, swap settings and FIFO contents must all start afresh after each soft reset, while the flash keeps streaming from the same position. The bench models the flash as a device that decodes the command word and then streams a computed byte sequence for as long as chip select is low. It then runs phases back to back: unswapped, byte swap, halfword swap, swap options set with the enable clear, and full reversal. A final phase discards a filled receive FIFO with a soft reset and then receives a fresh word. This checks every word against its position in the stream and checks the total count of SCLK edges after each phase.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    A_CTRL = 3'd0,
    A_PKT  = 3'd1,
    A_SWAP = 3'd2,
    A_CS   = 3'd3,
    A_STAT = 3'd4,
    A_TXD  = 3'd5,
    A_RXD  = 3'd6
  } reg_addr_e;

  // control register, bits 3..0
  typedef struct packed {
    logic rst;
    logic cpol;
    logic rx_en;
    logic tx_en;
  } ctrl_t;

  // swap register, bits 2..0
  typedef struct packed {
    logic hw;
    logic by;
    logic en;
  } swap_t;

endpackage

// File: rtl/spi_rd_fifo.sv
module spi_rd_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  logic [W-1:0]               wdata,
  input  logic                       pop,
  output logic [W-1:0]               rdata,
  output logic [$clog2(DEPTH):0]     level,
  output logic                       empty,
  output logic                       full
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [LW-1:0] cnt_q, cnt_n;
  logic          push_ok, pop_ok;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == LW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign rdata   = mem[rp_q];
  assign level   = cnt_q;

  always_comb begin
    wp_n  = wp_q;
    rp_n  = rp_q;
    cnt_n = cnt_q;
    if (flush) begin
      wp_n  = '0;
      rp_n  = '0;
      cnt_n = '0;
    end else begin
      if (push_ok) wp_n = wp_q + AW'(1);
      if (pop_ok)  rp_n = rp_q + AW'(1);
      case ({push_ok, pop_ok})
        2'b10:   cnt_n = cnt_q + LW'(1);
        2'b01:   cnt_n = cnt_q - LW'(1);
        default: cnt_n = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wp_q] <= wdata;
  end

  // R10
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> (level == LW'(DEPTH)));

  // R12
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == '0));

endmodule

// File: rtl/spi_rd_shifter.sv
module spi_rd_shifter #(
  parameter int W        = 32,
  parameter int DIV_HALF = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         abort,
  input  logic         start,
  input  logic [W-1:0] tx_word,
  input  logic         cpol,
  input  logic         miso,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] rx_word,
  output logic         sclk,
  output logic         mosi
);
  localparam int HC_W = $clog2(DIV_HALF + 1);
  localparam int EC_W = $clog2(2 * W);

  logic            busy_q, busy_n;
  logic            done_q, done_n;
  logic            sclk_q, sclk_n;
  logic [HC_W-1:0] hc_q, hc_n;
  logic [EC_W-1:0] ec_q, ec_n;
  logic [W-1:0]    tsh_q, tsh_n;
  logic [W-1:0]    rsh_q, rsh_n;

  always_comb begin
    busy_n = busy_q;
    done_n = 1'b0;
    sclk_n = sclk_q;
    hc_n   = hc_q;
    ec_n   = ec_q;
    tsh_n  = tsh_q;
    rsh_n  = rsh_q;
    if (abort) begin
      busy_n = 1'b0;
      sclk_n = cpol;
      hc_n   = '0;
      ec_n   = '0;
    end else if (!busy_q) begin
      sclk_n = cpol;
      if (start) begin
        busy_n = 1'b1;
        hc_n   = '0;
        ec_n   = '0;
        tsh_n  = tx_word;
      end
    end else if (hc_q == HC_W'(DIV_HALF - 1)) begin
      hc_n   = '0;
      sclk_n = ~sclk_q;
      ec_n   = ec_q + EC_W'(1);
      if (!ec_q[0]) begin
        // leading edge: sample
        rsh_n = {rsh_q[W-2:0], miso};
      end else begin
        // trailing edge: launch next bit
        tsh_n = {tsh_q[W-2:0], 1'b1};
        if (ec_q == EC_W'(2 * W - 1)) begin
          busy_n = 1'b0;
          done_n = 1'b1;
        end
      end
    end else begin
      hc_n = hc_q + HC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sclk_q <= 1'b0;
      hc_q   <= '0;
      ec_q   <= '0;
      tsh_q  <= '1;
      rsh_q  <= '0;
    end else begin
      busy_q <= busy_n;
      done_q <= done_n;
      sclk_q <= sclk_n;
      hc_q   <= hc_n;
      ec_q   <= ec_n;
      tsh_q  <= tsh_n;
      rsh_q  <= rsh_n;
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign rx_word = rsh_q;
  assign sclk    = sclk_q;
  assign mosi    = tsh_q[W-1];

  // R3
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sclk_q) && $stable(cpol)) |-> $past(busy_q));

endmodule

// File: rtl/spi_rd_swap.sv
module spi_rd_swap #(
  parameter int W = 32
) (
  input  logic [W-1:0] din,
  input  logic         en,
  input  logic         by,
  input  logic         hw,
  output logic [W-1:0] dout
);
  localparam int NB = W / 8;

  logic [1:0] sel;
  assign sel = {en & hw, en & by};

  for (genvar i = 0; i < NB; i++) begin : g_lane
    assign dout[8*i +: 8] = din[8*(i ^ int'(sel)) +: 8];
  end

endmodule

// File: rtl/spi_flash_stream_rd.sv
module spi_flash_stream_rd
  import spi_rd_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int CNT_W      = 16,
  parameter int DIV_HALF   = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        spi_sclk,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  localparam int AW    = $clog2(FIFO_DEPTH);
  localparam int LVL_W = AW + 1;

  // reset synchronizer
  logic [1:0] rst_sync_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  // register state
  ctrl_t            ctrl_q, ctrl_n;
  swap_t            swap_q, swap_n;
  logic             pkt_en_q, pkt_en_n;
  logic [CNT_W-1:0] pkt_cnt_q, pkt_cnt_n;
  logic [CNT_W-1:0] done_cnt_q, done_cnt_n;
  logic             cs_q, cs_n;
  logic             underrun_q, underrun_n;
  logic             cap_q, cap_n;

  // decode
  logic wr_ctrl, wr_pkt, wr_swap, wr_cs, wr_txd, rd_rxd;
  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign wr_pkt  = reg_wr && (reg_addr == A_PKT);
  assign wr_swap = reg_wr && (reg_addr == A_SWAP);
  assign wr_cs   = reg_wr && (reg_addr == A_CS);
  assign wr_txd  = reg_wr && (reg_addr == A_TXD);
  assign rd_rxd  = reg_rd && (reg_addr == A_RXD);

  // FIFOs and engine wiring
  logic [WORD_W-1:0] tx_head, rx_head, rx_word, rx_swapped, sh_word;
  logic [LVL_W-1:0]  tx_lvl, rx_lvl;
  logic              tx_empty, tx_full, rx_empty, rx_full;
  logic              tx_pop, rx_push, rx_pop;
  logic              sh_busy, sh_done, sh_start;
  logic              tx_avail, cnt_left;

  assign tx_avail = ctrl_q.tx_en && !tx_empty;
  assign cnt_left = ctrl_q.rx_en && pkt_en_q && (done_cnt_q < pkt_cnt_q);
  assign sh_start = !sh_busy && !sh_done && !ctrl_q.rst &&
                    (tx_avail || cnt_left) && !(cnt_left && rx_full);
  assign tx_pop   = sh_start && tx_avail;
  assign sh_word  = tx_avail ? tx_head : '1;
  assign rx_push  = sh_done && cap_q;
  assign rx_pop   = rd_rxd && !rx_empty;

  spi_rd_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk   (clk),
    .rst_n (rst_s_n),
    .flush (ctrl_q.rst),
    .push  (wr_txd),
    .wdata (reg_wdata),
    .pop   (tx_pop),
    .rdata (tx_head),
    .level (tx_lvl),
    .empty (tx_empty),
    .full  (tx_full)
  );

  spi_rd_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk   (clk),
    .rst_n (rst_s_n),
    .flush (ctrl_q.rst),
    .push  (rx_push),
    .wdata (rx_swapped),
    .pop   (rx_pop),
    .rdata (rx_head),
    .level (rx_lvl),
    .empty (rx_empty),
    .full  (rx_full)
  );

  spi_rd_shifter #(.W(WORD_W), .DIV_HALF(DIV_HALF)) u_shifter (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .abort   (ctrl_q.rst),
    .start   (sh_start),
    .tx_word (sh_word),
    .cpol    (ctrl_q.cpol),
    .miso    (spi_miso),
    .busy    (sh_busy),
    .done    (sh_done),
    .rx_word (rx_word),
    .sclk    (spi_sclk),
    .mosi    (spi_mosi)
  );

  spi_rd_swap #(.W(WORD_W)) u_swap (
    .din  (rx_word),
    .en   (swap_q.en),
    .by   (swap_q.by),
    .hw   (swap_q.hw),
    .dout (rx_swapped)
  );

  // next state
  always_comb begin
    ctrl_n     = ctrl_q;
    swap_n     = swap_q;
    pkt_en_n   = pkt_en_q;
    pkt_cnt_n  = pkt_cnt_q;
    done_cnt_n = done_cnt_q;
    cs_n       = cs_q;
    underrun_n = underrun_q;
    cap_n      = cap_q;
    if (wr_ctrl) ctrl_n = ctrl_t'(reg_wdata[3:0]);
    if (wr_swap) swap_n = swap_t'(reg_wdata[2:0]);
    if (wr_pkt) begin
      pkt_cnt_n = reg_wdata[CNT_W-1:0];
      pkt_en_n  = reg_wdata[16];
    end
    if (wr_cs) cs_n = reg_wdata[0];
    if (ctrl_q.rst) begin
      done_cnt_n = '0;
      underrun_n = 1'b0;
      cap_n      = 1'b0;
    end else begin
      if (rx_push)            done_cnt_n = done_cnt_q + CNT_W'(1);
      if (rd_rxd && rx_empty) underrun_n = 1'b1;
      if (sh_start)           cap_n      = cnt_left;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      ctrl_q     <= '0;
      swap_q     <= '0;
      pkt_en_q   <= 1'b0;
      pkt_cnt_q  <= '0;
      done_cnt_q <= '0;
      cs_q       <= 1'b1;
      underrun_q <= 1'b0;
      cap_q      <= 1'b0;
    end else begin
      ctrl_q     <= ctrl_n;
      swap_q     <= swap_n;
      pkt_en_q   <= pkt_en_n;
      pkt_cnt_q  <= pkt_cnt_n;
      done_cnt_q <= done_cnt_n;
      cs_q       <= cs_n;
      underrun_q <= underrun_n;
      cap_q      <= cap_n;
    end
  end

  assign spi_cs_n = cs_q;

  // read mux
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: reg_rdata[3:0] = ctrl_q;
      A_PKT: begin
        reg_rdata[CNT_W-1:0] = pkt_cnt_q;
        reg_rdata[16]        = pkt_en_q;
      end
      A_SWAP: reg_rdata[2:0] = swap_q;
      A_CS:   reg_rdata[0]   = cs_q;
      A_STAT: begin
        reg_rdata[21:15] = 7'(rx_lvl);
        reg_rdata[12:6]  = 7'(tx_lvl);
        reg_rdata[1]     = underrun_q;
        reg_rdata[0]     = tx_empty && !sh_busy;
      end
      A_RXD:   reg_rdata = rx_empty ? '0 : rx_head;
      default: reg_rdata = '0;
    endcase
  end

  logic tx_full_unused;
  assign tx_full_unused = tx_full;

  // R5
  pkt_limit_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rx_push && pkt_en_q && $stable(pkt_cnt_q)) |-> (done_cnt_q < pkt_cnt_q));

  // R11
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (underrun_q && !ctrl_q.rst) |=> underrun_q);

  // R2
  cs_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !reg_wr |=> $stable(spi_cs_n));

  // R13
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!ctrl_q.tx_en && !ctrl_q.rx_en && !sh_busy) |=> !sh_busy);

endmodule

// File: tb/spi_flash_stream_rd_test.sv
`timescale 1ns/1ps
module spi_flash_stream_rd_test;

  localparam logic [2:0] AD_CTRL = 3'd0, AD_PKT = 3'd1, AD_SWAP = 3'd2,
                         AD_CS = 3'd3, AD_STAT = 3'd4, AD_TXD = 3'd5, AD_RXD = 3'd6;
  localparam int unsigned BASE = 32'h0000_0120;

  logic        clk, rst_n;
  logic        reg_wr, reg_rd;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        spi_sclk, spi_cs_n, spi_mosi, spi_miso;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  spi_flash_stream_rd uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] fbyte(input int unsigned a);
    return 8'(a * 37 + 11);
  endfunction

  // flash device model
  int unsigned rises = 0;
  int unsigned bitcnt = 0;
  logic [31:0] cmd_cap = '0;
  bit          fill_bad = 0;

  always @(posedge spi_sclk) begin
    rises++;
    if (!spi_cs_n) begin
      if (bitcnt < 32) cmd_cap = {cmd_cap[30:0], spi_mosi};
      else if (spi_mosi !== 1'b1) fill_bad = 1;
      bitcnt++;
    end
  end

  always @(negedge spi_sclk) begin
    if (!spi_cs_n && bitcnt >= 32) begin
      int unsigned k;
      logic [7:0] b;
      k = bitcnt - 32;
      b = fbyte(int'(cmd_cap[23:0]) + k / 8);
      spi_miso = b[7 - (k % 8)];
    end
  end

  always @(posedge spi_cs_n) bitcnt = 0;

  // scoreboard
  logic [31:0] exp_q[$];
  int unsigned pos = 0;
  int unsigned exp_rises = 0;

  function automatic logic [31:0] exp_word(input int unsigned p, input logic [1:0] sel);
    logic [31:0] raw, o;
    for (int i = 0; i < 4; i++) raw[8*(3-i) +: 8] = fbyte(BASE + 4*p + i);
    for (int l = 0; l < 4; l++) o[8*l +: 8] = raw[8*(l ^ int'(sel)) +: 8];
    return o;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #5 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  // driver: queue expected words
  task automatic drive_expect(input int n, input logic [1:0] sel, input bit keep);
    for (int i = 0; i < n; i++) begin
      if (keep) exp_q.push_back(exp_word(pos, sel));
      pos++;
    end
  endtask

  // monitor: pop design output and compare
  task automatic monitor_drain(input int n, input string req);
    logic [31:0] d, e;
    for (int i = 0; i < n; i++) begin
      rd(AD_RXD, d);
      e = (exp_q.size() > 0) ? exp_q.pop_front() : 32'hDEAD_BEEF;
      chk(req, d, e);
    end
  endtask

  task automatic wait_rx(input int n, input string req);
    logic [31:0] s;
    int tries;
    tries = 0;
    do begin
      rd(AD_STAT, s);
      tries++;
    end while (s[21:15] != 7'(n) && tries < 3000);
    chk(req, 32'(s[21:15]), 32'(n));
  endtask

  task automatic run_phase(input logic [31:0] swapv, input logic [1:0] sel,
                           input int n, input bit keep, input bit hold, input string req);
    logic [31:0] s;
    wr(AD_CTRL, 32'h9);
    wr(AD_SWAP, swapv);
    wr(AD_PKT, 32'h0001_0000 | 32'(n));
    drive_expect(n, sel, keep);
    if (hold) begin
      wr(AD_CTRL, 32'h1);
      repeat (300) @(negedge clk);
      chk("R13 rx path off clocks nothing", rises, exp_rises);
    end
    wr(AD_CTRL, 32'h3);
    wait_rx(n, req);
    repeat (300) @(negedge clk);
    exp_rises += 32 * n;
    chk("R5 clock stops after count", rises, exp_rises);
    rd(AD_STAT, s);
    chk("R9 status levels", s, (32'(n) << 15) | 32'h1);
  endtask

  initial begin
    logic [31:0] s;
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0; spi_miso = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1
    chk("R1 cs_n at reset", 32'(spi_cs_n), 32'h1);
    chk("R1 sclk at reset", 32'(spi_sclk), 32'h0);
    rd(AD_STAT, s);
    chk("R1 status at reset", s, 32'h1);

    // R11
    rd(AD_RXD, s);
    chk("R11 empty read returns zero", s, 32'h0);
    rd(AD_STAT, s);
    chk("R11 underrun set", s, 32'h3);
    rd(AD_RXD, s);
    rd(AD_STAT, s);
    chk("R11 underrun sticky", s, 32'h3);
    wr(AD_CTRL, 32'h8);
    wr(AD_CTRL, 32'h0);
    rd(AD_STAT, s);
    chk("R12 soft reset clears underrun", s, 32'h1);

    // R2
    wr(AD_CS, 32'h0);
    chk("R2 cs low", 32'(spi_cs_n), 32'h0);

    // R13 transmit held while disabled
    wr(AD_TXD, 32'h0300_0000 | BASE);
    repeat (200) @(negedge clk);
    rd(AD_STAT, s);
    chk("R13 tx held status", s, 32'h40);
    chk("R13 tx held no clock", rises, 32'h0);

    // R3 / R4 command word
    wr(AD_CTRL, 32'h1);
    begin
      int tries;
      tries = 0;
      do begin rd(AD_STAT, s); tries++; end while (!s[0] && tries < 2000);
    end
    chk("R4 tx done after command", s, 32'h1);
    exp_rises = 32;
    chk("R3 command bit count", rises, exp_rises);
    chk("R3 command word", cmd_cap, 32'h0300_0000 | BASE);

    // R5 R7 R9 R6: plain stream
    run_phase(32'h0, 2'b00, 4, 1'b1, 1'b0, "R5 four words received");
    monitor_drain(4, "R7 plain word");
    chk("R6 filler all ones", 32'(fill_bad), 32'h0);
    chk("R2 cs held low", 32'(spi_cs_n), 32'h0);

    // R8 swap variants
    run_phase(32'h3, 2'b01, 2, 1'b1, 1'b1, "R8 byte swap count");
    monitor_drain(2, "R8 byte swap word");
    run_phase(32'h5, 2'b10, 2, 1'b1, 1'b0, "R8 halfword swap count");
    monitor_drain(2, "R8 halfword swap word");
    run_phase(32'h6, 2'b00, 2, 1'b1, 1'b0, "R8 swap disabled count");
    monitor_drain(2, "R8 swap disabled word");
    run_phase(32'h7, 2'b11, 2, 1'b1, 1'b0, "R8 full reverse count");
    monitor_drain(2, "R8 full reverse word");

    // R12 flush of filled FIFO, then fresh count
    run_phase(32'h0, 2'b00, 2, 1'b0, 1'b0, "R12 fill before flush");
    wr(AD_CTRL, 32'h9);
    rd(AD_STAT, s);
    chk("R12 rx fifo flushed", s, 32'h1);
    run_phase(32'h0, 2'b00, 1, 1'b1, 1'b0, "R12 progress restarted");
    monitor_drain(1, "R12 word after flush");
    chk("R6 filler all ones later", 32'(fill_bad), 32'h0);

    // R10 tx overflow
    wr(AD_CTRL, 32'h8);
    wr(AD_CTRL, 32'h0);
    for (int i = 0; i < 65; i++) wr(AD_TXD, 32'h1234_0000 | 32'(i));
    rd(AD_STAT, s);
    chk("R10 tx fifo caps at 64", s, 32'h1000);
    chk("R13 tx full but disabled", rises, exp_rises);
    wr(AD_CTRL, 32'h8);
    wr(AD_CTRL, 32'h0);
    rd(AD_STAT, s);
    chk("R12 tx fifo flushed", s, 32'h1);

    wr(AD_CS, 32'h1);
    chk("R2 cs high", 32'(spi_cs_n), 32'h1);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule